// File: doc/BRIEF.md
# Selectable-Feedback Four-Stage Shift Register

A four-stage serial-in, parallel-out register. On each enabled rising clock edge, every stage moves one place down the chain. Stage 1 loads a bit taken from a two-way selector. One selector input is an external serial data bit. The other is a feedback bit formed from the register's own stage outputs.

A two-bit mode input sets the feedback function. The register can pass the last stage straight back, return its complement, or XOR the last stage with stage 3 or with stage 2. With these choices the block works as a serial loader, a circulating ring, a twisted-ring counter, a maximal-length pseudo-random sequencer, or a short-cycle XOR sequencer. The mode can change at any clock.

Top module: `fbk_shreg4`

## Requirements
- R1: A synchronous active-high reset `rst` clears all four stages to 0 at the next rising edge. Reset takes priority over enable.
- R2: When `shift_en` is 1, each rising edge moves the old value of stage k-1 into stage k, for k = 2..4. Stage k is bit k-1 of `stages`.
- R3: When `use_fb` is 0, stage 1 loads `ser_in`. When `use_fb` is 1, stage 1 loads the feedback bit, and `ser_in` is ignored.
- R4: Mode 2'b00 (ring): the feedback is stage 4, so a loaded pattern circulates. The pattern 1,1,0,0 repeats every 4 states.
- R5: Mode 2'b01 (inverted ring): the feedback is the complement of stage 4. Starting from all zeros, the sequence repeats after 8 states.
- R6: Mode 2'b10: the feedback is stage 4 XOR stage 3. Starting from any nonzero state, the register visits all 15 nonzero states before repeating.
- R7: Mode 2'b11: the feedback is stage 4 XOR stage 2. Starting from all ones, the cycle repeats in fewer than 15 states (6 states).
- R8: In both XOR modes, the all-zero state stays all zero while feedback is selected.
- R9: When `shift_en` is 0, `stages` holds its value across clock edges, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear |
| shift_en | input | 1 | Shift enable (clock enable) |
| use_fb | input | 1 | 1 selects the feedback bit, 0 selects ser_in |
| fb_mode | input | 2 | Feedback function: 00 ring, 01 inverted ring, 10 taps 4^3, 11 taps 4^2 |
| ser_in | input | 1 | External serial data bit |
| stages | output | 4 | Stage outputs; bit 0 is stage 1, bit 3 is stage 4 |

## Verification
Each result is due exactly one rising edge after the inputs that cause it, because there is a single register between the inputs and `stages`. The bench drives inputs on the falling edge and then waits one full cycle. It reads `stages` at the next falling edge, half a period after the edge that updated it. Sequence checks read one state per cycle, find the period from when the start state comes back, and compare every state with a bench model of the shift and feedback rules.

// File: rtl/fbk_shreg4.sv
module fbk_shreg4 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         use_fb,
  input  logic [1:0]   fb_mode,
  input  logic         ser_in,
  output logic [W-1:0] stages
);
  logic fb, din;

  always_comb begin
    unique case (fb_mode)
      2'b00:   fb = stages[W-1];
      2'b01:   fb = ~stages[W-1];
      2'b10:   fb = stages[W-1] ^ stages[W-2];
      default: fb = stages[W-1] ^ stages[W-3];
    endcase
  end

  assign din = use_fb ? fb : ser_in;

  always_ff @(posedge clk) begin
    if (rst)           stages <= '0;
    else if (shift_en) stages <= {stages[W-2:0], din};
  end
endmodule

module fbk_shreg4_chk (
  input logic       clk,
  input logic       rst,
  input logic       shift_en,
  input logic       use_fb,
  input logic [1:0] fb_mode,
  input logic       ser_in,
  input logic [3:0] stages
);
  logic past_ok = 1'b0;
  always_ff @(posedge clk) past_ok <= 1'b1;

  // R1
  clear_on_rst_chk: assert property (@(posedge clk) rst |=> stages == 4'b0);
  // R2
  shift_move_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && shift_en) |=> stages[3:1] == $past(stages[2:0]));
  // R3
  serial_load_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && shift_en && !use_fb) |=> stages[0] == $past(ser_in));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !shift_en) |=> $stable(stages));
  // R8
  lockup_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && use_fb && fb_mode[1] && stages == 4'b0) |=> stages == 4'b0);
  // R5
  twist_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && shift_en && use_fb && fb_mode == 2'b01) |=> stages[0] != $past(stages[3]));
endmodule

bind fbk_shreg4 fbk_shreg4_chk u_chk (.*);

// File: tb/test_fbk_shreg4.sv
module test_fbk_shreg4;
  logic clk = 0, rst = 1, shift_en = 0, use_fb = 0, ser_in = 0;
  logic [1:0] fb_mode = 2'b00;
  logic [3:0] stages;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fbk_shreg4 i_fbk_shreg4 (.*);

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [3:0] nxt(logic [3:0] s, logic [1:0] m);
    logic f;
    case (m)
      2'b00: f = s[3];
      2'b01: f = !s[3];
      2'b10: f = s[3] ^ s[2];
      default: f = s[3] ^ s[1];
    endcase
    return {s[2:0], f};
  endfunction

  task automatic load(logic [3:0] p);
    use_fb = 0; shift_en = 1;
    for (int i = 3; i >= 0; i--) begin ser_in = p[i]; step(); end
  endtask

  task automatic period(string req, logic [1:0] m, int exp_len);
    logic [3:0] start, model;
    int len;
    start = stages; model = stages; len = 0;
    fb_mode = m; use_fb = 1; shift_en = 1;
    do begin
      step(); len++;
      model = nxt(model, m);
      chk(req, stages, model);
    end while (stages != start && len < 20);
    chk(req, 4'(len), 4'(exp_len));
  endtask

  task automatic t_reset();
    rst = 1; shift_en = 0; step(); step();
    chk("R1", stages, 4'b0);
    rst = 0;
  endtask

  task automatic t_load();
    load(4'b1011);
    chk("R2", stages, 4'b1011);
    chk("R3", stages, 4'b1011);
  endtask

  task automatic t_ring();
    load(4'b1100);
    period("R4", 2'b00, 4);
  endtask

  task automatic t_twist();
    rst = 1; step(); rst = 0;
    period("R5", 2'b01, 8);
  endtask

  task automatic t_max();
    load(4'b1111);
    period("R6", 2'b10, 15);
  endtask

  task automatic t_alt();
    load(4'b1111);
    period("R7", 2'b11, 6);
  endtask

  task automatic t_lock();
    for (int m = 2; m < 4; m++) begin
      load(4'b0000);
      fb_mode = 2'(m); use_fb = 1; ser_in = 1;
      step(); step(); step();
      chk("R8", stages, 4'b0000);
    end
  endtask

  task automatic t_ignore();
    load(4'b0101);
    use_fb = 1; fb_mode = 2'b00; ser_in = 1;
    step();
    chk("R3", stages, 4'b1010);
  endtask

  task automatic t_hold();
    load(4'b0110);
    shift_en = 0; use_fb = 0; ser_in = 1; step(); step();
    chk("R9", stages, 4'b0110);
    use_fb = 1; fb_mode = 2'b01; step();
    chk("R9", stages, 4'b0110);
    rst = 1; step(); rst = 0;
    chk("R1", stages, 4'b0000);
  endtask

  initial begin
    @(negedge clk);
    t_reset(); t_load(); t_ring(); t_twist(); t_max();
    t_alt(); t_lock(); t_ignore(); t_hold();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule